// File: doc/BRIEF.md
# Sampled External Interrupt Sense Unit

This block watches a set of external interrupt pins (two by default) and turns activity on them into interrupt request flags and gated request outputs. Each pin is first brought into the clock domain through a synchroniser, and a further registered copy of the synchronised value is kept. Edges are found by comparing the synchronised sample with that older copy.

Each channel has its own 2-bit sense code, which picks one of four modes:
- **Low level** (0): non-latching. The request follows the synchronised pin and is active while it is low.
- **Any change** (1): latched.
- **Falling edge** (2): latched.
- **Rising edge** (3): latched.

A latched flag is cleared by the channel's acknowledge input or by a write-one-to-clear register write. Requests leave the block only when the channel's enable bit and the global interrupt-enable input are both 1. The enable bits live in a small write-only register.

Top module: `xint_sense_unit`

## Requirements
- R1: After reset every flag, every enable bit and every request output is 0.
- R2: With sense code 0, the channel's request is active while the synchronised pin is low, two clock edges after the pin changes. It drops as soon as the pin is high again, and the flag output stays 0.
- R3: With sense code 1, any change of the pin sets the channel flag on the third clock edge after the change.
- R4: With sense code 2, a high-to-low transition sets the flag on the third edge, and a low-to-high transition sets nothing.
- R5: With sense code 3, a low-to-high transition sets the flag on the third edge, and a high-to-low transition sets nothing.
- R6: In the latched modes, a pulse held for two clock periods or more always sets the flag.
- R7: A request output is 1 only when the channel's enable bit is 1, the global enable input is 1, and the channel's request is active. The flag itself is not affected by the gating.
- R8: An enable-register write takes effect on the next edge. Bit 7 is the enable for channel 1 and bit 6 is the enable for channel 0. The other bits have no effect.
- R9: A latched flag clears on the edge after its acknowledge input is 1, or on the edge after a flag-register write with 1 in its bit (bit 7 for channel 1, bit 6 for channel 0). Writing 0 to the bit leaves the flag unchanged.
- R10: When a set event and a clear event hit the same channel in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and is released synchronously inside the block. |
| pin_i | input | NUM_CH | External interrupt pins. These are asynchronous inputs. |
| sense_i | input | 2*NUM_CH | Sense codes. Bits [2k+1:2k] belong to channel k. |
| gie_i | input | 1 | Global interrupt enable |
| en_we_i | input | 1 | Enable-register write strobe |
| en_wdata_i | input | REG_W | Enable-register write data |
| flg_we_i | input | 1 | Flag-register write strobe. Each 1 bit clears the matching flag. |
| flg_wdata_i | input | REG_W | Flag-register write data |
| ack_i | input | NUM_CH | Per-channel acknowledge. It clears the latched flag. |
| flag_o | output | NUM_CH | Latched edge flags |
| irq_o | output | NUM_CH | Gated interrupt requests |

## Verification
A synchroniser or edge history that goes wrong shows up at the ports within three edges. It appears as a flag that sets on the wrong transition, or one cycle early or late. In low-level mode it appears as a request that lags or leads the pin. A flag register that loses its value, or fails to clear, becomes visible on flag_o at the very next edge. With both enables set, the same fault reaches irq_o at that edge too. A corrupted enable bit is hidden until a request is active, so the bench checks every enable write against a pending request.

// File: rtl/xint_pkg.sv
package xint_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/xint_rst_sync.sv
module xint_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/xint_sync.sv
// Synchroniser chain plus one extra history stage per bit.
module xint_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] smp_o,
  output logic [W-1:0] prev_o
);
  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] stg_q [DEPTH];
  logic [W-1:0] stg_d [DEPTH];

  always_comb begin
    stg_d[0] = d_i;
    for (int i = 1; i < DEPTH; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign smp_o  = stg_q[STAGES-1];
  assign prev_o = stg_q[STAGES];
endmodule

// File: rtl/xint_edge_chan.sv
// One channel: mode decode, latched flag, raw request.
module xint_edge_chan
  import xint_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   smp_i,
  input  logic   prev_i,
  input  sense_e sense_i,
  input  logic   clr_i,
  output logic   flag_o,
  output logic   req_o
);
  logic rise, fall, set_ev;
  logic flag_q, flag_d, flag_en;

  always_comb begin
    rise = smp_i & ~prev_i;
    fall = ~smp_i & prev_i;
    unique case (sense_i)
      SNS_LOW:  set_ev = 1'b0;
      SNS_ANY:  set_ev = rise | fall;
      SNS_FALL: set_ev = fall;
      SNS_RISE: set_ev = rise;
      default:  set_ev = 1'b0;
    endcase
  end

  // Set has priority over clear.
  always_comb begin
    flag_en = set_ev | clr_i;
    flag_d  = set_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign req_o  = (sense_i == SNS_LOW) ? ~smp_i : flag_q;
endmodule

// File: rtl/xint_en_reg.sv
// Enable bits, channel k held at register bit REG_W-NUM_CH+k.
module xint_en_reg #(
  parameter int NUM_CH = 2,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [NUM_CH-1:0] en_o
);
  localparam int LSB = REG_W - NUM_CH;

  logic [NUM_CH-1:0] en_q, en_d;

  always_comb en_d = wdata_i[LSB +: NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= '0;
    else if (we_i) en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/xint_sense_unit.sv
module xint_sense_unit
  import xint_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     pin_i,
  input  logic [2*NUM_CH-1:0]   sense_i,
  input  logic                  gie_i,
  input  logic                  en_we_i,
  input  logic [REG_W-1:0]      en_wdata_i,
  input  logic                  flg_we_i,
  input  logic [REG_W-1:0]      flg_wdata_i,
  input  logic [NUM_CH-1:0]     ack_i,
  output logic [NUM_CH-1:0]     flag_o,
  output logic [NUM_CH-1:0]     irq_o
);
  localparam int LSB = REG_W - NUM_CH;

  logic              rst_q_n;
  logic [NUM_CH-1:0] smp_w, prev_w, en_w, req_w, clr_w;

  xint_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  xint_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q_n), .d_i(pin_i), .smp_o(smp_w), .prev_o(prev_w)
  );

  xint_en_reg #(.NUM_CH(NUM_CH), .REG_W(REG_W)) u_en (
    .clk(clk), .rst_n(rst_q_n), .we_i(en_we_i), .wdata_i(en_wdata_i), .en_o(en_w)
  );

  always_comb begin
    clr_w = ack_i | ({NUM_CH{flg_we_i}} & flg_wdata_i[LSB +: NUM_CH]);
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    xint_edge_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_q_n),
      .smp_i  (smp_w[k]),
      .prev_i (prev_w[k]),
      .sense_i(sense_e'(sense_i[2*k +: 2])),
      .clr_i  (clr_w[k]),
      .flag_o (flag_o[k]),
      .req_o  (req_w[k])
    );
  end

  always_comb irq_o = req_w & en_w & {NUM_CH{gie_i}};
endmodule

// File: rtl/xint_sense_chk.sv
module xint_sense_chk #(
  parameter int NUM_CH = 2,
  parameter int REG_W  = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_CH-1:0]   smp,
  input logic [NUM_CH-1:0]   prev,
  input logic [NUM_CH-1:0]   en,
  input logic [2*NUM_CH-1:0] sense_i,
  input logic                gie_i,
  input logic                flg_we_i,
  input logic [REG_W-1:0]    flg_wdata_i,
  input logic [NUM_CH-1:0]   ack_i,
  input logic [NUM_CH-1:0]   flag_o,
  input logic [NUM_CH-1:0]   irq_o
);
  localparam int LSB = REG_W - NUM_CH;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_a
    a_r2_level_never_latches: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_i[2*k +: 2] == 2'b00) |=> !$rose(flag_o[k]));

    a_r3_flag_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o[k]) |-> $past(smp[k] != prev[k]));

    a_r7_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[k] |-> (gie_i && en[k]));

    a_r9_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o[k]) |-> $past(ack_i[k] || (flg_we_i && flg_wdata_i[LSB+k])));

    a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_i[2*k +: 2] == 2'b11 && smp[k] && !prev[k]) |=> flag_o[k]);
  end
endmodule

bind xint_sense_unit xint_sense_chk #(.NUM_CH(NUM_CH), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .smp(smp_w), .prev(prev_w), .en(en_w),
  .sense_i(sense_i), .gie_i(gie_i), .flg_we_i(flg_we_i), .flg_wdata_i(flg_wdata_i),
  .ack_i(ack_i), .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/sim_xint_sense_unit.sv
`timescale 1ns/1ps
module sim_xint_sense_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] pin, ack;
  logic [3:0] sense;
  logic       gie, en_we, flg_we;
  logic [7:0] en_wdata, flg_wdata;
  logic [1:0] flag_o, irq_o;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int         cyc;
    logic [1:0] f;
    logic [1:0] i;
    string      tag;
  } item_t;
  item_t q[$];
  item_t it;

  always #2 clk = ~clk;

  xint_sense_unit u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .sense_i(sense), .gie_i(gie),
    .en_we_i(en_we), .en_wdata_i(en_wdata), .flg_we_i(flg_we), .flg_wdata_i(flg_wdata),
    .ack_i(ack), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(input int d, input logic [1:0] f, input logic [1:0] i, input string tag);
    item_t x;
    x.cyc = cyc + d; x.f = f; x.i = i; x.tag = tag;
    q.push_back(x);
  endtask

  // Monitor: samples 1 ns after each rising edge, away from input changes.
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #1;
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        it = q.pop_front();
        n_chk++;
        if (it.cyc != cyc || flag_o !== it.f || irq_o !== it.i) begin
          n_fail++;
          $display("FAIL %s: flag=%b irq=%b expected flag=%b irq=%b at cycle %0d",
                   it.tag, flag_o, irq_o, it.f, it.i, it.cyc);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin = 2'b11; ack = 2'b00; sense = 4'b0000; gie = 1'b0;
    en_we = 1'b0; en_wdata = 8'h00; flg_we = 1'b0; flg_wdata = 8'h00;
    tick(3);
    rst_n = 1'b1;
    tick(5);
    expect_at(1, 2'b00, 2'b00, "R1 reset state"); tick(2);

    // R8: enable register bit positions
    gie = 1'b1; pin = 2'b10;
    en_we = 1'b1; en_wdata = 8'h3F;
    expect_at(1, 2'b00, 2'b00, "R8 low bits ignored"); tick(1); en_we = 1'b0;
    tick(4);
    expect_at(1, 2'b00, 2'b00, "R8 no enable no request"); tick(1);
    en_we = 1'b1; en_wdata = 8'h40;
    expect_at(1, 2'b00, 2'b01, "R8 bit6 enables ch0"); tick(1); en_we = 1'b0;
    en_we = 1'b1; en_wdata = 8'h80;
    expect_at(1, 2'b00, 2'b00, "R8 bit7 only ch1"); tick(1); en_we = 1'b0;
    en_we = 1'b1; en_wdata = 8'hC0;
    expect_at(1, 2'b00, 2'b01, "R8 both enabled"); tick(1); en_we = 1'b0;

    // R2: low-level mode follows the pin, no latching
    pin = 2'b11;
    expect_at(2, 2'b00, 2'b00, "R2 high releases request"); tick(3);
    pin = 2'b10;
    expect_at(1, 2'b00, 2'b00, "R2 latency one edge");
    expect_at(2, 2'b00, 2'b01, "R2 low requests"); tick(3);
    pin = 2'b00;
    expect_at(2, 2'b00, 2'b11, "R2 both low, no flag"); tick(3);
    pin = 2'b11; tick(4);

    // R4 / R5: ch0 rising, ch1 falling
    sense = 4'b1011; tick(3);
    pin = 2'b00;
    expect_at(2, 2'b00, 2'b00, "R4 not yet at edge two");
    expect_at(3, 2'b10, 2'b10, "R4 fall sets ch1, R5 fall ignored ch0"); tick(4);
    pin = 2'b11;
    expect_at(3, 2'b11, 2'b11, "R5 rise sets ch0"); tick(4);

    // R9: clearing
    flg_we = 1'b1; flg_wdata = 8'h40;
    expect_at(1, 2'b10, 2'b10, "R9 w1c ch0"); tick(1); flg_we = 1'b0;
    flg_we = 1'b1; flg_wdata = 8'h3F;
    expect_at(1, 2'b10, 2'b10, "R9 zero in bit7 keeps ch1"); tick(1); flg_we = 1'b0;
    ack = 2'b10;
    expect_at(1, 2'b00, 2'b00, "R9 ack clears ch1"); tick(1); ack = 2'b00;
    tick(2);

    // R3: any change
    sense = 4'b0101; tick(3);
    pin = 2'b00;
    expect_at(3, 2'b11, 2'b11, "R3 fall on both"); tick(4);
    ack = 2'b11;
    expect_at(1, 2'b00, 2'b00, "R9 ack both"); tick(1); ack = 2'b00;
    pin = 2'b01;
    expect_at(3, 2'b01, 2'b01, "R3 rise on ch0"); tick(4);

    // R7: gating
    gie = 1'b0;
    expect_at(1, 2'b01, 2'b00, "R7 global off"); tick(1);
    gie = 1'b1;
    expect_at(1, 2'b01, 2'b01, "R7 global on"); tick(1);
    en_we = 1'b1; en_wdata = 8'h80;
    expect_at(1, 2'b01, 2'b00, "R7 channel off keeps flag"); tick(1); en_we = 1'b0;
    en_we = 1'b1; en_wdata = 8'hC0;
    expect_at(1, 2'b01, 2'b01, "R7 channel on"); tick(1); en_we = 1'b0;
    ack = 2'b01;
    expect_at(1, 2'b00, 2'b00, "R9 ack ch0"); tick(1); ack = 2'b00;
    tick(2);

    // R6: two-period pulse, rising mode
    sense = 4'b1111; tick(3);
    pin = 2'b00;
    expect_at(3, 2'b00, 2'b00, "R5 fall ignored"); tick(4);
    pin = 2'b01;
    expect_at(3, 2'b01, 2'b01, "R6 short pulse caught"); tick(2);
    pin = 2'b00; tick(2);
    expect_at(1, 2'b01, 2'b01, "R6 flag holds after pulse"); tick(2);

    // R10: set and acknowledge in the same cycle
    pin = 2'b10; tick(2);
    ack = 2'b10;
    expect_at(1, 2'b11, 2'b11, "R10 set wins"); tick(1); ack = 2'b00;
    expect_at(1, 2'b11, 2'b11, "R10 flag stays"); tick(2);

    tick(3);
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule